// File: doc/BRIEF.md
# Masked SIMD Word-to-Byte Narrowing Unit

This vector execution slice takes a packed source vector of 16-bit lanes and narrows each lane to 8 bits. Three narrowing rules are available: keep the low byte, clamp as a signed value, or clamp as an unsigned value. Narrowed bytes are packed upward from the least-significant byte, so result byte j comes from source word j. The number of active lanes follows a vector-length select of 128, 256 or 512 source bits.

A per-lane write mask, with an enable, decides which lanes are written. When the destination is a register, a masked-off lane either keeps the old destination byte or is cleared. Everything from half the vector length up to the top of the 512-bit result is cleared. When the destination is memory, masked-off lanes are only left alone. The block shows this through a per-byte store enable, and the data bytes of disabled lanes read as zero. A 4-bit reserved operand field must be all ones. Any other value raises an invalid-operation flag and suppresses all result data and enables.

Inputs are sampled on a valid strobe. Results come out of a single register stage one cycle later, marked by a one-cycle output valid pulse.

Top module: `narrow_w2b_unit`

## Requirements
- R1: With mode code 0 or 3, each active result byte j equals bits [16j+7:16j] of the source (plain truncation).
- R2: With mode code 1, each source word is read as signed: values above 127 give 0x7F, values below -128 give 0x80, and all others give their low byte.
- R3: With mode code 2, each source word is read as unsigned: values above 255 give 0xFF, and all others give their low byte.
- R4: Vector-length code 0 gives 8 active lanes, code 1 gives 16, and codes 2 and 3 give 32. Result byte j occupies res_o bits [8j+7:8j] and comes from src_i bits [16j+15:16j].
- R5: For a register destination, a lane whose mask bit is 0 while mask_en_i is 1 keeps the old byte from old_dst_i [8j+7:8j] when zero_sel_i is 0, and becomes 0x00 when zero_sel_i is 1. With mask_en_i at 0, every active lane is written regardless of mask_i.
- R6: For a register destination, result bytes at and above the active lane count are 0, all of res_o from bit 256 upward is 0, and store_be_o is all zeros.
- R7: For a memory destination, store_be_o bit j is 1 exactly when lane j is active and (mask_en_i is 0 or mask_i bit j is 1). Result byte j carries the narrowed value when its enable is 1 and 0x00 otherwise. zero_sel_i has no effect.
- R8: When rsvd_i is not 4'b1111, bad_op_o is 1, res_o is all zeros and store_be_o is all zeros. Otherwise bad_op_o is 0.
- R9: The outputs take their new values at the clock edge after an edge where in_valid is 1, and out_valid pulses high for exactly that one cycle. Without in_valid the outputs hold their values. A synchronous active-high reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe for all operand inputs |
| src_i | input | 512 | Packed 16-bit source lanes |
| old_dst_i | input | 256 | Low half of the old destination register |
| mode_i | input | 2 | Narrowing rule: 0/3 truncate, 1 signed clamp, 2 unsigned clamp |
| vlen_sel_i | input | 2 | Vector length: 0 = 8 lanes, 1 = 16, 2/3 = 32 |
| mask_i | input | 32 | Per-lane write mask |
| mask_en_i | input | 1 | Apply mask_i when 1 |
| zero_sel_i | input | 1 | Register destination: clear (1) or keep (0) masked-off bytes |
| to_mem_i | input | 1 | Destination is memory when 1 |
| rsvd_i | input | 4 | Reserved operand field, must be 4'b1111 |
| out_valid | output | 1 | One-cycle pulse marking new outputs |
| res_o | output | 512 | New destination value or store data |
| store_be_o | output | 32 | Per-byte store enable for memory destinations |
| bad_op_o | output | 1 | Invalid reserved field |

## Verification
The unit holds its state only in the output register, so a wrong value captured there shows up at the ports in the cycle right after the strobe. It then stays visible through every idle cycle until the next strobe. A wrong lane count or a wrong mask decode shows up as misplaced bytes or misplaced enables near the 8-, 16- and 32-lane boundaries. Clamp errors show up only on the boundary words on either side of each limit, so those words sit in every lane position. A register that fails to hold, or a valid pulse that lasts too long, shows up on the idle cycle after a strobe.

// File: rtl/narrow_pkg.sv
package narrow_pkg;

   typedef enum logic [1:0] {
      NM_TRUNC     = 2'd0,
      NM_SSAT      = 2'd1,
      NM_USAT      = 2'd2,
      NM_TRUNC_ALT = 2'd3
   } narrow_mode_e;

   localparam logic [3:0] RSVD_OK = 4'b1111;

   // Active lanes for a vector-length code, given the widest configuration.
   function automatic int unsigned lane_count(input logic [1:0] vsel,
                                              input int unsigned max_lanes);
      case (vsel)
         2'd0:    lane_count = max_lanes / 4;
         2'd1:    lane_count = max_lanes / 2;
         default: lane_count = max_lanes;
      endcase
   endfunction

endpackage

// File: rtl/narrow_lane_conv.sv
module narrow_lane_conv
   import narrow_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8,
   parameter bit SAT_EN = 1'b1
) (
   input  logic [WORD_W-1:0] word_i,
   input  narrow_mode_e      mode_i,
   output logic [BYTE_W-1:0] byte_o
);

   localparam int HI_S = WORD_W - BYTE_W + 1;
   localparam int HI_U = WORD_W - BYTE_W;

   logic [BYTE_W-1:0] low_byte;
   assign low_byte = word_i[BYTE_W-1:0];

   generate
      if (SAT_EN) begin : g_sat
         logic [HI_S-1:0] top_s;
         logic [HI_U-1:0] top_u;
         logic            s_ovf;
         logic            u_ovf;
         logic [BYTE_W-1:0] s_clamp;

         assign top_s   = word_i[WORD_W-1:BYTE_W-1];
         assign top_u   = word_i[WORD_W-1:BYTE_W];
         assign s_ovf   = !((&top_s) || !(|top_s));
         assign u_ovf   = |top_u;
         assign s_clamp = word_i[WORD_W-1] ? {1'b1, {(BYTE_W-1){1'b0}}}
                                           : {1'b0, {(BYTE_W-1){1'b1}}};

         always_comb begin
            case (mode_i)
               NM_SSAT: byte_o = s_ovf ? s_clamp : low_byte;
               NM_USAT: byte_o = u_ovf ? {BYTE_W{1'b1}} : low_byte;
               default: byte_o = low_byte;
            endcase
         end
      end else begin : g_trunc_only
         logic unused_mode;
         assign unused_mode = ^mode_i;
         assign byte_o = low_byte;
      end
   endgenerate

endmodule

// File: rtl/narrow_lane_merge.sv
module narrow_lane_merge #(
   parameter int BYTE_W = 8
) (
   input  logic [BYTE_W-1:0] conv_i,
   input  logic [BYTE_W-1:0] old_i,
   input  logic              active_i,
   input  logic              wr_i,
   input  logic              zero_i,
   input  logic              mem_i,
   input  logic              fault_i,
   output logic [BYTE_W-1:0] byte_o,
   output logic              be_o
);

   assign be_o = mem_i && active_i && wr_i && !fault_i;

   always_comb begin
      if (fault_i || !active_i) begin
         byte_o = '0;
      end else if (mem_i) begin
         byte_o = wr_i ? conv_i : '0;
      end else if (wr_i) begin
         byte_o = conv_i;
      end else begin
         byte_o = zero_i ? '0 : old_i;
      end
   end

endmodule

// File: rtl/narrow_w2b_unit.sv
module narrow_w2b_unit
   import narrow_pkg::*;
#(
   parameter int MAX_LANES = 32,
   parameter int WORD_W    = 16,
   parameter int BYTE_W    = 8,
   parameter bit SAT_EN    = 1'b1,
   localparam int VEC_W    = MAX_LANES * WORD_W,
   localparam int OUT_W    = MAX_LANES * BYTE_W
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic [VEC_W-1:0]     src_i,
   input  logic [OUT_W-1:0]     old_dst_i,
   input  logic [1:0]           mode_i,
   input  logic [1:0]           vlen_sel_i,
   input  logic [MAX_LANES-1:0] mask_i,
   input  logic                 mask_en_i,
   input  logic                 zero_sel_i,
   input  logic                 to_mem_i,
   input  logic [3:0]           rsvd_i,
   output logic                 out_valid,
   output logic [VEC_W-1:0]     res_o,
   output logic [MAX_LANES-1:0] store_be_o,
   output logic                 bad_op_o
);

   localparam int PAD_W = VEC_W - OUT_W;

   generate
      if (WORD_W != 2 * BYTE_W) begin : g_chk_width
         $error("narrow_w2b_unit: WORD_W must be twice BYTE_W");
      end
      if ((MAX_LANES % 4) != 0 || MAX_LANES < 4) begin : g_chk_lanes
         $error("narrow_w2b_unit: MAX_LANES must be a positive multiple of 4");
      end
   endgenerate

   narrow_mode_e        mode;
   int unsigned         lanes;
   logic                fault;
   logic [OUT_W-1:0]    nxt_res;
   logic [MAX_LANES-1:0] nxt_be;

   assign mode  = narrow_mode_e'(mode_i);
   assign fault = (rsvd_i != RSVD_OK);

   always_comb begin
      lanes = lane_count(vlen_sel_i, MAX_LANES);
   end

   generate
      for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
         logic [BYTE_W-1:0] conv_b;
         logic              act;
         logic              wr;

         assign act = (j < lanes);
         assign wr  = !mask_en_i || mask_i[j];

         narrow_lane_conv #(
            .WORD_W (WORD_W),
            .BYTE_W (BYTE_W),
            .SAT_EN (SAT_EN)
         ) u_conv (
            .word_i (src_i[j*WORD_W +: WORD_W]),
            .mode_i (mode),
            .byte_o (conv_b)
         );

         narrow_lane_merge #(
            .BYTE_W (BYTE_W)
         ) u_merge (
            .conv_i   (conv_b),
            .old_i    (old_dst_i[j*BYTE_W +: BYTE_W]),
            .active_i (act),
            .wr_i     (wr),
            .zero_i   (zero_sel_i),
            .mem_i    (to_mem_i),
            .fault_i  (fault),
            .byte_o   (nxt_res[j*BYTE_W +: BYTE_W]),
            .be_o     (nxt_be[j])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         res_o      <= '0;
         store_be_o <= '0;
         bad_op_o   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            res_o      <= {{PAD_W{1'b0}}, nxt_res};
            store_be_o <= nxt_be;
            bad_op_o   <= fault;
         end
      end
   end

endmodule

// File: rtl/narrow_w2b_chk.sv
module narrow_w2b_chk #(
   parameter int MAX_LANES = 32,
   parameter int WORD_W    = 16,
   parameter int BYTE_W    = 8,
   localparam int VEC_W    = MAX_LANES * WORD_W
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 in_valid,
   input logic [1:0]           vlen_sel_i,
   input logic [MAX_LANES-1:0] mask_i,
   input logic                 mask_en_i,
   input logic                 zero_sel_i,
   input logic                 to_mem_i,
   input logic [3:0]           rsvd_i,
   input logic                 out_valid,
   input logic [VEC_W-1:0]     res_o,
   input logic [MAX_LANES-1:0] store_be_o,
   input logic                 bad_op_o
);

   a_r9_pulse: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   a_r9_idle: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   a_r9_hold: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(res_o) && $stable(store_be_o) && $stable(bad_op_o)));

   a_r8_flag: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (bad_op_o == ($past(rsvd_i) != 4'b1111)));

   a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
      bad_op_o |-> (store_be_o == '0 && res_o == '0));

   a_r6_no_be: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !to_mem_i) |=> (store_be_o == '0));

   a_r4_be_lanes: assert property (@(posedge clk) disable iff (rst)
      (in_valid && vlen_sel_i == 2'd0) |=> (store_be_o[MAX_LANES-1:MAX_LANES/4] == '0));

   a_r7_be_mask: assert property (@(posedge clk) disable iff (rst)
      (in_valid && to_mem_i && mask_en_i) |=> ((store_be_o & ~$past(mask_i)) == '0));

   a_r5_zero_all: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !to_mem_i && mask_en_i && zero_sel_i && mask_i == '0) |=> (res_o == '0));

endmodule

bind narrow_w2b_unit narrow_w2b_chk #(
   .MAX_LANES (MAX_LANES),
   .WORD_W    (WORD_W),
   .BYTE_W    (BYTE_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .in_valid   (in_valid),
   .vlen_sel_i (vlen_sel_i),
   .mask_i     (mask_i),
   .mask_en_i  (mask_en_i),
   .zero_sel_i (zero_sel_i),
   .to_mem_i   (to_mem_i),
   .rsvd_i     (rsvd_i),
   .out_valid  (out_valid),
   .res_o      (res_o),
   .store_be_o (store_be_o),
   .bad_op_o   (bad_op_o)
);

// File: tb/sim_narrow_w2b_unit.sv
module sim_narrow_w2b_unit;

   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst;
   logic         in_valid;
   logic [511:0] src;
   logic [255:0] old_dst;
   logic [1:0]   mode;
   logic [1:0]   vsel;
   logic [31:0]  mask;
   logic         mask_en;
   logic         zero_sel;
   logic         to_mem;
   logic [3:0]   rsvd;
   logic         out_valid;
   logic [511:0] res;
   logic [31:0]  store_be;
   logic         bad_op;

   always #(CLK_PERIOD/2) clk = ~clk;

   narrow_w2b_unit u0 (
      .clk        (clk),
      .rst        (rst),
      .in_valid   (in_valid),
      .src_i      (src),
      .old_dst_i  (old_dst),
      .mode_i     (mode),
      .vlen_sel_i (vsel),
      .mask_i     (mask),
      .mask_en_i  (mask_en),
      .zero_sel_i (zero_sel),
      .to_mem_i   (to_mem),
      .rsvd_i     (rsvd),
      .out_valid  (out_valid),
      .res_o      (res),
      .store_be_o (store_be),
      .bad_op_o   (bad_op)
   );

   int    n_checks = 0;
   int    n_errors = 0;
   string cur_tag  = "R9";
   bit    started  = 1'b0;

   logic         e_vld;
   logic [511:0] e_res;
   logic [31:0]  e_be;
   logic         e_bad;
   string        e_tag = "R9";

   logic [15:0] bwords [8] = '{16'h007F, 16'h0080, 16'hFF80, 16'hFF7F,
                               16'h00FF, 16'h0100, 16'h8000, 16'h7FFF};

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [511:0] act, input logic [511:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] narrow_one(input logic [15:0] w, input logic [1:0] m);
      int sv;
      int uv;
      sv = $signed(w);
      uv = w;
      if (m == 2'd1) begin
         if (sv > 127)       return 8'h7F;
         else if (sv < -128) return 8'h80;
         else                return w[7:0];
      end else if (m == 2'd2) begin
         if (uv > 255) return 8'hFF;
         else          return w[7:0];
      end
      return w[7:0];
   endfunction

   // Behavioural reference, updated at every rising edge.
   always @(posedge clk) begin
      int          lanes;
      logic [511:0] r;
      logic [31:0]  b;
      if (rst) begin
         e_vld <= 1'b0;
         e_res <= '0;
         e_be  <= '0;
         e_bad <= 1'b0;
         e_tag <= "R9";
      end else begin
         e_vld <= in_valid;
         e_tag <= in_valid ? cur_tag : "R9";
         if (in_valid) begin
            lanes = (vsel == 2'd0) ? 8 : (vsel == 2'd1) ? 16 : 32;
            r = '0;
            b = '0;
            if (rsvd == 4'hF) begin
               for (int j = 0; j < lanes; j++) begin
                  bit wr;
                  logic [7:0] c;
                  wr = !mask_en || mask[j];
                  c  = narrow_one(src[16*j +: 16], mode);
                  if (to_mem) begin
                     b[j] = wr;
                     r[8*j +: 8] = wr ? c : 8'h00;
                  end else begin
                     r[8*j +: 8] = wr ? c : (zero_sel ? 8'h00 : old_dst[8*j +: 8]);
                  end
               end
            end
            e_res <= r;
            e_be  <= b;
            e_bad <= (rsvd != 4'hF);
         end
      end
   end

   always @(negedge clk) begin
      if (started) begin
         check(out_valid == e_vld, "R9", "out_valid", 512'(out_valid), 512'(e_vld));
         check(bad_op == e_bad, "R8", "bad_op", 512'(bad_op), 512'(e_bad));
         check(store_be == e_be, e_tag, "store_be", 512'(store_be), 512'(e_be));
         check(res == e_res, e_tag, "result", res, e_res);
      end
   end

   task automatic rnd512(output logic [511:0] v);
      for (int k = 0; k < 16; k++) v[32*k +: 32] = $urandom;
   endtask

   task automatic bound512(input int ofs, output logic [511:0] v);
      for (int k = 0; k < 32; k++) v[16*k +: 16] = bwords[(k + ofs) % 8];
   endtask

   task automatic issue(input logic [511:0] s, input logic [255:0] o, input logic [1:0] m,
                        input logic [1:0] vs, input logic [31:0] mk, input logic me,
                        input logic zs, input logic mem, input logic [3:0] rv,
                        input string tag);
      @(negedge clk);
      src = s; old_dst = o; mode = m; vsel = vs; mask = mk;
      mask_en = me; zero_sel = zs; to_mem = mem; rsvd = rv;
      cur_tag = tag;
      in_valid = 1'b1;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         logic [511:0] s;
         @(negedge clk);
         in_valid = 1'b0;
         rnd512(s);
         src = s;
         mask = $urandom;
         rsvd = 4'($urandom);
      end
   endtask

   initial begin
      logic [511:0] s;
      logic [511:0] o;
      rst = 1'b1; in_valid = 1'b0; src = '0; old_dst = '0; mode = '0; vsel = '0;
      mask = '0; mask_en = 1'b0; zero_sel = 1'b0; to_mem = 1'b0; rsvd = 4'hF;
      @(posedge clk);
      started = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      // R1: truncation with both mode codes
      for (int p = 0; p < 8; p++) begin
         bound512(p, s); rnd512(o);
         issue(s, o[255:0], 2'd0, 2'd2, '0, 1'b0, 1'b0, 1'b0, 4'hF, "R1");
         issue(s, o[255:0], 2'd3, 2'd2, '0, 1'b0, 1'b0, 1'b0, 4'hF, "R1");
      end
      idle(2);
      // R2: signed clamp; R3: unsigned clamp
      for (int p = 0; p < 8; p++) begin
         bound512(p, s);
         issue(s, '0, 2'd1, 2'd2, '0, 1'b0, 1'b0, 1'b0, 4'hF, "R2");
         issue(s, '0, 2'd2, 2'd2, '0, 1'b0, 1'b0, 1'b0, 4'hF, "R3");
         rnd512(s);
         issue(s, '0, 2'd1, 2'd3, '0, 1'b0, 1'b0, 1'b0, 4'hF, "R2");
         issue(s, '0, 2'd2, 2'd3, '0, 1'b0, 1'b0, 1'b0, 4'hF, "R3");
      end
      idle(1);
      // R4 / R6: lane counts, upper bytes cleared for register destinations
      for (int p = 0; p < 6; p++) begin
         rnd512(s);
         issue(s, '1, 2'(p % 3), 2'd0, '0, 1'b0, 1'b0, 1'b0, 4'hF, "R6");
         issue(s, '1, 2'(p % 3), 2'd1, '0, 1'b0, 1'b0, 1'b0, 4'hF, "R4");
         issue(s, '1, 2'(p % 3), 2'd3, '0, 1'b0, 1'b0, 1'b0, 4'hF, "R4");
      end
      idle(2);
      // R5: merge, zero, and mask disabled
      for (int p = 0; p < 6; p++) begin
         rnd512(s); rnd512(o);
         issue(s, o[255:0], 2'(p % 3), 2'(p % 4), $urandom, 1'b1, 1'b0, 1'b0, 4'hF, "R5");
         issue(s, o[255:0], 2'(p % 3), 2'(p % 4), $urandom, 1'b1, 1'b1, 1'b0, 4'hF, "R5");
         issue(s, o[255:0], 2'(p % 3), 2'(p % 4), '0, 1'b1, 1'b1, 1'b0, 4'hF, "R5");
         issue(s, o[255:0], 2'(p % 3), 2'(p % 4), '0, 1'b0, 1'b1, 1'b0, 4'hF, "R5");
      end
      idle(1);
      // R7: memory destination, zero_sel has no effect
      for (int p = 0; p < 8; p++) begin
         rnd512(s); rnd512(o);
         issue(s, o[255:0], 2'(p % 3), 2'(p % 4), $urandom, 1'b1, 1'(p % 2), 1'b1, 4'hF, "R7");
         issue(s, o[255:0], 2'(p % 3), 2'(p % 4), $urandom, 1'b0, 1'b1, 1'b1, 4'hF, "R7");
      end
      idle(2);
      // R8: bad reserved field on both destinations
      for (int p = 0; p < 15; p++) begin
         rnd512(s); rnd512(o);
         issue(s, o[255:0], 2'(p % 3), 2'd2, $urandom, 1'(p % 2), 1'b0, 1'(p % 2), 4'(p), "R8");
      end
      issue(s, o[255:0], 2'd0, 2'd2, '1, 1'b1, 1'b0, 1'b1, 4'hF, "R7");
      // R9: outputs hold across idle cycles with changing inputs
      idle(5);
      // Mixed random traffic
      for (int p = 0; p < 400; p++) begin
         rnd512(s); rnd512(o);
         issue(s, o[255:0], 2'($urandom), 2'($urandom), $urandom, 1'($urandom),
               1'($urandom), 1'($urandom), (($urandom % 8) == 0) ? 4'($urandom) : 4'hF, "R4");
         if (($urandom % 4) == 0) idle(1);
      end
      idle(2);
      // R9: reset clears outputs
      @(negedge clk);
      rst = 1'b1;
      idle(2);
      @(negedge clk);
      rst = 1'b0;
      idle(2);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule